// File: doc/BRIEF.md
# Shared Interrupt Distributor with Per-CPU Acknowledge Interface

This block collects edge-signalled interrupt request lines, latches each rising edge as a pending event, and routes every pending interrupt to one or more CPUs. A distributor stage holds a global forwarding switch, one enable bit per interrupt ID, and an 8-bit CPU-selection field per ID. A CPU interface per target adds a local forwarding switch and a priority threshold. The interface also provides an acknowledge register that hands out the lowest eligible ID and an end-of-interrupt register that retires it.

Software drives the block through a word-addressed register bus built as a pair of valid/ready streams. A command is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. A read produces one response beat on `rsp_valid`, and that beat stays stable until `rsp_ready` takes it. Only one read may be outstanding: `cmd_ready` stays low while a response beat is waiting. Writes produce no response. Each CPU sees one level-sensitive `irq_out` bit.

Top module: `irq_hub`

## Requirements
- R1: The distributor control register at address 0x00, bit 0, resets to 0. While it is 0, every `irq_out` bit is 0 and acknowledge reads return 1023.
- R2: Interrupt ID n has its enable bit at bit n%32 of the word at address 0x10+n/32. Writing 1 to that bit sets the enable. Writing 1 to the same bit of the word at 0x18+n/32 clears it. Writing 0 to either word changes nothing. Reading either address returns the enable bits.
- R3: ID n has its 8-bit CPU-selection field at bits [8*(n%4)+7 : 8*(n%4)] of the word at 0x40+n/4. The field reads back as written. Bit c of the field routes the ID to CPU c.
- R4: CPU c has its registers at 0x80+8*c. Bit 0 of the control register at offset 0 resets to 0. While that bit is 0, `irq_out[c]` is 0 and acknowledge reads from CPU c return 1023.
- R5: Every interrupt has the fixed priority 0xA0. The 8-bit priority mask at CPU offset 1 resets to 0. CPU c is signalled only when 0xA0 is strictly less than its mask.
- R6: A 0-to-1 transition seen on `irq_in[n]` at a clock edge makes ID n pending at that edge. Reading 0x20+n/32 returns the pending bits.
- R7: A read of CPU offset 2 (acknowledge) returns the lowest ID that is pending, enabled, routed to that CPU and not active. The same read moves that ID from pending to active. If no ID qualifies, the read returns 1023 and changes nothing.
- R8: An active ID is not signalled again until its number is written to CPU offset 3 (end-of-interrupt). Writing an ID that is not active has no effect.
- R9: Writing 1 to bit n%32 of the word at 0x20+n/32 clears the pending state of ID n. Writing 0 has no effect.
- R10: After a read is accepted, `rsp_valid` rises on the next clock edge. The response beat holds with stable data until `rsp_ready` is high, and `cmd_ready` is low for as long as the beat waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IDS | Interrupt request lines, rising edge sets pending |
| cmd_valid | input | 1 | Register command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NUM_CPUS | Interrupt line per CPU |

## Verification
The bench sweeps every ID through the full life cycle: enable, edge, signalled on the right CPU only, acknowledged, re-edged while active, retired and disabled. A design that swaps the word/bit or word/byte indexing would signal the wrong CPU, or none. A second edge that arrives while an ID is active must stay hidden until end-of-interrupt. A design that lost the active state would raise the line again at once, and a design that dropped the second edge would fail to raise it after retirement. Several IDs are made pending at once, out of order, and the acknowledge sequence must come back ascending and end in 1023. The remaining corner cases are these:
- mask values 0xA0 against 0xA1, where an off-by-one comparison shows up;
- end-of-interrupt writes naming inactive IDs, which a careless design would let clear the active ID;
- zero writes to the clear-pending register;
- a stalled read response that must hold its data while new commands are refused.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [7:0] PRIO_FIXED = 8'hA0;
  localparam logic [9:0] ID_NONE    = 10'd1023;
  localparam int A_GCTRL    = 'h00;
  localparam int A_SEN      = 'h10;
  localparam int A_CEN      = 'h18;
  localparam int A_CPEND    = 'h20;
  localparam int A_TGT      = 'h40;
  localparam int A_CPU      = 'h80;
  localparam int CPU_STRIDE = 8;
  localparam int OFF_CTRL   = 0;
  localparam int OFF_PMASK  = 1;
  localparam int OFF_ACK    = 2;
  localparam int OFF_EOI    = 3;

  function automatic logic [7:0] reg_at(input int v);
    return v[7:0];
  endfunction
endpackage

// File: rtl/irq_hub_dist.sv
module irq_hub_dist
  import irq_hub_pkg::*;
#(
  parameter int NUM_IDS = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_IDS-1:0]     irq_in,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [NUM_IDS-1:0]     ack_clr,
  input  logic [7:0]             rd_addr,
  output logic [31:0]            rd_data,
  output logic                   glb_en,
  output logic [NUM_IDS-1:0]     enable,
  output logic [NUM_IDS-1:0]     pending,
  output logic [NUM_IDS-1:0]     req_q,
  output logic [8*NUM_IDS-1:0]   targets
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      enable  <= '0;
      pending <= '0;
      req_q   <= '0;
      targets <= '0;
    end else begin
      req_q <= irq_in;
      if (wr_en && wr_addr == reg_at(A_GCTRL)) glb_en <= wr_data[0];
      for (int i = 0; i < NUM_IDS; i++) begin
        if (wr_en && wr_data[i%32]) begin
          if (wr_addr == reg_at(A_SEN + i/32))      enable[i] <= 1'b1;
          else if (wr_addr == reg_at(A_CEN + i/32)) enable[i] <= 1'b0;
        end
        // a fresh edge wins over any clear in the same cycle
        if (irq_in[i] && !req_q[i])
          pending[i] <= 1'b1;
        else if (ack_clr[i] ||
                 (wr_en && wr_data[i%32] && wr_addr == reg_at(A_CPEND + i/32)))
          pending[i] <= 1'b0;
        if (wr_en && wr_addr == reg_at(A_TGT + i/4))
          targets[8*i +: 8] <= wr_data[8*(i%4) +: 8];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == reg_at(A_GCTRL)) rd_data[0] = glb_en;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (rd_addr == reg_at(A_SEN + i/32) || rd_addr == reg_at(A_CEN + i/32))
        rd_data[i%32] = enable[i];
      if (rd_addr == reg_at(A_CPEND + i/32))
        rd_data[i%32] = pending[i];
      if (rd_addr == reg_at(A_TGT + i/4))
        rd_data[8*(i%4) +: 8] = targets[8*i +: 8];
    end
  end
endmodule

// File: rtl/irq_hub_cpu.sv
module irq_hub_cpu
  import irq_hub_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int CPU_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               glb_en,
  input  logic [NUM_IDS-1:0] pending,
  input  logic [NUM_IDS-1:0] enable,
  input  logic [NUM_IDS-1:0] active,
  input  logic [NUM_IDS-1:0] tgt_col,
  input  logic [7:0]         rd_addr,
  output logic               irq,
  output logic [9:0]         win_id,
  output logic [31:0]        rd_data
);
  localparam int BASE = A_CPU + CPU_IDX * CPU_STRIDE;

  logic               ctrl_en;
  logic [7:0]         pmask;
  logic [NUM_IDS-1:0] elig;
  logic               pass;
  logic               hit;
  logic [9:0]         idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      pmask   <= 8'h00;
    end else if (wr_en) begin
      if (wr_addr == reg_at(BASE + OFF_CTRL))  ctrl_en <= wr_data[0];
      if (wr_addr == reg_at(BASE + OFF_PMASK)) pmask   <= wr_data;
    end
  end

  assign elig = pending & enable & ~active & tgt_col & {NUM_IDS{glb_en}};
  assign pass = ctrl_en && (PRIO_FIXED < pmask);

  // lowest index wins: scan from the top so lower IDs overwrite
  always_comb begin
    hit = 1'b0;
    idx = ID_NONE;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = 10'(i);
      end
    end
  end

  assign irq    = pass && hit;
  assign win_id = irq ? idx : ID_NONE;

  always_comb begin
    rd_data = '0;
    if (rd_addr == reg_at(BASE + OFF_CTRL))  rd_data[0]   = ctrl_en;
    if (rd_addr == reg_at(BASE + OFF_PMASK)) rd_data[7:0] = pmask;
    if (rd_addr == reg_at(BASE + OFF_ACK))   rd_data[9:0] = win_id;
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IDS-1:0]  irq_in,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [7:0]          cmd_addr,
  input  logic [31:0]         cmd_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_rdata,
  output logic [NUM_CPUS-1:0] irq_out
);
  logic               accept, wr_en, rd_go;
  logic               glb_en;
  logic [NUM_IDS-1:0] enable, pending, req_q, active;
  logic [NUM_IDS-1:0] ack_clr, eoi_clr;
  logic [8*NUM_IDS-1:0] targets;
  logic [31:0]        dist_rd, rd_all;
  logic [31:0]        cpu_rd [NUM_CPUS];
  logic [9:0]         win_id [NUM_CPUS];
  logic [NUM_CPUS-1:0] ack_hit, eoi_hit;
  logic               ack_fire, eoi_fire;

  assign cmd_ready = !rsp_valid;
  assign accept    = cmd_valid && cmd_ready;
  assign wr_en     = accept && cmd_write;
  assign rd_go     = accept && !cmd_write;

  irq_hub_dist #(.NUM_IDS(NUM_IDS)) u_dist (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .wr_en(wr_en), .wr_addr(cmd_addr), .wr_data(cmd_wdata),
    .ack_clr(ack_clr), .rd_addr(cmd_addr), .rd_data(dist_rd),
    .glb_en(glb_en), .enable(enable), .pending(pending),
    .req_q(req_q), .targets(targets)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_IDS-1:0] tgt_col;
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_col
      assign tgt_col[i] = targets[8*i + c];
    end
    irq_hub_cpu #(.NUM_IDS(NUM_IDS), .CPU_IDX(c)) u_cpu (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(cmd_addr), .wr_data(cmd_wdata[7:0]),
      .glb_en(glb_en), .pending(pending), .enable(enable),
      .active(active), .tgt_col(tgt_col), .rd_addr(cmd_addr),
      .irq(irq_out[c]), .win_id(win_id[c]), .rd_data(cpu_rd[c])
    );
    assign ack_hit[c] = rd_go && irq_out[c] &&
                        cmd_addr == reg_at(A_CPU + c*CPU_STRIDE + OFF_ACK);
    assign eoi_hit[c] = wr_en &&
                        cmd_addr == reg_at(A_CPU + c*CPU_STRIDE + OFF_EOI);
  end

  assign ack_fire = |ack_hit;
  assign eoi_fire = |eoi_hit;

  always_comb begin
    ack_clr = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      for (int i = 0; i < NUM_IDS; i++)
        if (ack_hit[c] && win_id[c] == 10'(i)) ack_clr[i] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++)
      eoi_clr[i] = eoi_fire && active[i] && cmd_wdata[9:0] == 10'(i);
  end

  always_comb begin
    rd_all = dist_rd;
    for (int c = 0; c < NUM_CPUS; c++) rd_all = rd_all | cpu_rd[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      active <= (active | ack_clr) & ~eoi_clr;
      if (rd_go) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_all;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                glb_en,
  input logic [NUM_CPUS-1:0] irq_out,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic [NUM_IDS-1:0]  irq_in,
  input logic [NUM_IDS-1:0]  req_q,
  input logic [NUM_IDS-1:0]  pending,
  input logic [NUM_IDS-1:0]  active,
  input logic                ack_fire,
  input logic                eoi_fire
);
  p_glb_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> irq_out == '0);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
    p_edge_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_in[i] && !req_q[i] |=> pending[i]);
  end

  p_ack_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(active & ~$past(active))) |-> $past(ack_fire));

  p_eoi_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~active & $past(active))) |-> $past(eoi_fire));
endmodule

bind irq_hub irq_hub_chk #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .irq_out(irq_out),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .irq_in(irq_in), .req_q(req_q), .pending(pending), .active(active),
  .ack_fire(ack_fire), .eoi_fire(eoi_fire)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  localparam int N = 64;
  localparam int C = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          cmd_valid, cmd_ready, cmd_write;
  logic [7:0]    cmd_addr;
  logic [31:0]   cmd_wdata;
  logic          rsp_valid, rsp_ready;
  logic [31:0]   rsp_rdata;
  logic [C-1:0]  irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_hub #(.NUM_IDS(N), .NUM_CPUS(C)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] cpu_a(input int c, input int off);
    return 8'(8'h80 + 8*c + off);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic pulse(input int id);
    @(negedge clk);
    irq_in[id] = 1'b1;
    @(negedge clk);
    irq_in[id] = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_in = '0; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 reset irq_out", 32'(irq_out), 0);
    check("R10 reset cmd_ready", 32'(cmd_ready), 1);
    check("R10 reset rsp_valid", 32'(rsp_valid), 0);
    rd(8'h00, d); check("R1 reset global ctrl", d, 0);
    rd(cpu_a(0, 1), d); check("R5 reset pmask", d, 0);
    rd(cpu_a(1, 0), d); check("R4 reset cpu ctrl", d, 0);

    // R2 enable word set/clear sweep
    for (int w = 0; w < N/32; w++) begin
      logic [31:0] p;
      p = 32'hA5C3_0F1E ^ (32'(w) * 32'h1111_1111);
      wr(8'(8'h10 + w), p);
      rd(8'(8'h10 + w), d); check("R2 set-enable readback", d, p);
      rd(8'(8'h18 + w), d); check("R2 clear-enable addr readback", d, p);
      wr(8'(8'h18 + w), 32'h0F0F_0F0F);
      rd(8'(8'h10 + w), d); check("R2 clear-enable ones", d, p & ~32'h0F0F_0F0F);
      wr(8'(8'h10 + w), 32'h0);
      wr(8'(8'h18 + w), 32'h0);
      rd(8'(8'h10 + w), d); check("R2 zero writes ignored", d, p & ~32'h0F0F_0F0F);
      wr(8'(8'h18 + w), 32'hFFFF_FFFF);
      rd(8'(8'h10 + w), d); check("R2 clear all", d, 0);
    end

    // R3 target field sweep
    for (int w = 0; w < N/4; w++) begin
      logic [31:0] p;
      p = (32'h0102_0304 * 32'(w + 1)) ^ 32'h5A5A_5A5A;
      wr(8'(8'h40 + w), p);
      rd(8'(8'h40 + w), d); check("R3 target readback", d, p);
    end
    for (int w = 0; w < N/4; w++) wr(8'(8'h40 + w), 32'h0201_0201);

    wr(8'h00, 1);
    for (int c = 0; c < C; c++) begin
      wr(cpu_a(c, 0), 1);
      wr(cpu_a(c, 1), 32'hFF);
    end

    // per-ID life-cycle sweep
    for (int id = 0; id < N; id++) begin
      int c;
      int oc;
      c = id % 2; oc = 1 - c;
      wr(8'(8'h10 + id/32), 32'h1 << (id % 32));
      check("R2 enabled idle", 32'(irq_out), 0);
      pulse(id);
      rd(8'(8'h20 + id/32), d); check("R6 pending bit", d, 32'h1 << (id % 32));
      check("R3 routed cpu", 32'(irq_out), 32'h1 << c);
      rd(cpu_a(oc, 2), d); check("R3 other cpu ack none", d, 1023);
      rd(cpu_a(c, 2), d); check("R7 ack id", d, 32'(id));
      check("R7 irq drops after ack", 32'(irq_out), 0);
      pulse(id);
      check("R8 active not resignalled", 32'(irq_out), 0);
      wr(cpu_a(c, 3), 32'(id));
      check("R8 resignal after eoi", 32'(irq_out), 32'h1 << c);
      rd(cpu_a(c, 2), d); check("R7 second ack", d, 32'(id));
      wr(cpu_a(c, 3), 32'(id));
      wr(8'(8'h18 + id/32), 32'h1 << (id % 32));
      check("R2 disabled idle", 32'(irq_out), 0);
    end

    // lowest-ID order
    for (int w = 0; w < N/4; w++) wr(8'(8'h40 + w), 32'h0101_0101);
    for (int w = 0; w < N/32; w++) wr(8'(8'h10 + w), 32'hFFFF_FFFF);
    pulse(40); pulse(7); pulse(33); pulse(63);
    check("R3 cpu1 unrouted", 32'(irq_out[1]), 0);
    rd(cpu_a(0, 2), d); check("R7 order 1st", d, 7);
    rd(cpu_a(0, 2), d); check("R7 order 2nd", d, 33);
    rd(cpu_a(0, 2), d); check("R7 order 3rd", d, 40);
    rd(cpu_a(0, 2), d); check("R7 order 4th", d, 63);
    rd(cpu_a(0, 2), d); check("R7 none left", d, 1023);
    wr(cpu_a(0, 3), 7); wr(cpu_a(0, 3), 33); wr(cpu_a(0, 3), 40); wr(cpu_a(0, 3), 63);
    check("R8 all retired idle", 32'(irq_out), 0);

    // EOI of inactive ID ignored
    pulse(5);
    rd(cpu_a(0, 2), d); check("R7 ack 5", d, 5);
    wr(cpu_a(0, 3), 6);
    wr(cpu_a(0, 3), 1023);
    pulse(5);
    check("R8 wrong eoi ignored", 32'(irq_out[0]), 0);
    wr(cpu_a(0, 3), 5);
    check("R8 right eoi", 32'(irq_out[0]), 1);
    rd(cpu_a(0, 2), d); check("R7 ack 5 again", d, 5);
    wr(cpu_a(0, 3), 5);

    // clear-pending
    pulse(10); pulse(12);
    wr(8'h20, 0);
    rd(8'h20, d); check("R9 zero write ignored", d, (32'h1 << 10) | (32'h1 << 12));
    wr(8'h20, 32'h1 << 10);
    rd(8'h20, d); check("R9 clear one", d, 32'h1 << 12);
    rd(cpu_a(0, 2), d); check("R9 remaining wins", d, 12);
    wr(cpu_a(0, 3), 12);

    // mask boundary
    pulse(3);
    wr(cpu_a(0, 1), 32'hA0);
    check("R5 mask A0 blocks", 32'(irq_out[0]), 0);
    rd(cpu_a(0, 2), d); check("R5 blocked ack none", d, 1023);
    wr(cpu_a(0, 1), 32'hA1);
    check("R5 mask A1 passes", 32'(irq_out[0]), 1);
    wr(cpu_a(0, 1), 32'hFF);

    // cpu interface enable
    wr(cpu_a(0, 0), 0);
    check("R4 cpu off", 32'(irq_out[0]), 0);
    rd(cpu_a(0, 2), d); check("R4 cpu off ack none", d, 1023);
    wr(cpu_a(0, 0), 1);
    check("R4 cpu on", 32'(irq_out[0]), 1);

    // global enable
    wr(8'h00, 0);
    check("R1 global off", 32'(irq_out), 0);
    rd(cpu_a(0, 2), d); check("R1 global off ack none", d, 1023);
    wr(8'h00, 1);
    check("R1 global on", 32'(irq_out[0]), 1);
    rd(cpu_a(0, 2), d); check("R7 ack 3", d, 3);
    wr(cpu_a(0, 3), 3);

    // back-pressure on read response
    rsp_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 rsp valid", 32'(rsp_valid), 1);
    check("R10 rsp data", rsp_rdata, 1);
    repeat (3) @(negedge clk);
    check("R10 rsp held", 32'(rsp_valid), 1);
    check("R10 cmd blocked", 32'(cmd_ready), 0);
    check("R10 data stable", rsp_rdata, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 rsp drained", 32'(rsp_valid), 0);
    check("R10 cmd ready again", 32'(cmd_ready), 1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule